// File: doc/BRIEF.md
# Device MMU Control and Status Register Unit

This block is the register front end of a device-side memory management unit. Software talks to it over a simple 32-bit register bus. Through it, software programs the translation table base and issues commands to the translation engine through a single command-code register. Software also reads a status word and handles the fault and bus-error interrupts that the engine raises. The address translation itself lives in a separate engine. This unit only holds the control state that the engine obeys and the status that the engine reports.

Each command write is decoded into one of seven actions: paging on, paging off, stall request on, stall request off, whole-cache invalidate, fault acknowledge, and a full return to power-on state. A stall handshake is granted only once the engine reports idle. A stall request is refused while a page fault is outstanding or while paging is off. A write to the per-line invalidate register sends the written address to the engine as a one-cycle pulse. Interrupt causes are latched in a raw register, cleared by writing ones, and gated by a mask. The interrupt line is the OR of the unmasked pending causes.

Top module: `mmu_ctl_regs`

## Requirements
- R1: The table-base register (offset 0x00) keeps only bits [31:12]. Reads return bits [11:0] as zero, so writing 0xCAFEBABE reads back 0xCAFEB000. It resets to zero and drives `tbl_base_o`.
- R2: Command code 0 written to offset 0x08 sets the paging flag, and code 1 clears it. The flag is status bit 0 (offset 0x04) and `paging_en_o`.
- R3: Command code 2 sets the stall request while paging is on. Status bit 2 (stall active) becomes 1 on the first clock edge where the request is held and `engine_idle` is 1. Code 3 drops the request, and stall active falls on the next edge. Status bit 31 is always the inverse of bit 2.
- R4: Code 2 has no effect while fault-active (status bit 1) is set. Codes 2 and 3 have no effect while paging is off.
- R5: A `fault_evt` pulse sets status bit 1. It captures `fault_addr_i` into offset 0x0C and `fault_is_wr` into status bit 5. Command code 5 clears status bit 1.
- R6: Raw interrupt register (offset 0x14) bit 0 is set by `fault_evt` and bit 1 by `buserr_evt`. Both may be pending together. Writing a 1 to a bit of offset 0x18 clears that raw bit, except that an event in the same cycle wins.
- R7: The mask register (offset 0x1C) resets to zero. The masked status at offset 0x20 equals raw AND mask, and `irq_o` is the OR of the masked bits.
- R8: Command code 4 produces a one-cycle `zap_all_o` pulse on the edge after the write. A write to offset 0x10 produces a one-cycle `zap_line_o` pulse, with the written value on `zap_line_addr_o`.
- R9: Command code 6 returns the unit to its power-on state. Table base, paging, stall, fault-active, fault address, raw interrupts, mask and gating bit all become zero.
- R10: A command write whose value is not in the range 0..6 changes nothing.
- R11: Status bit 3 mirrors `engine_idle`, and status bit 4 mirrors `replay_empty`.
- R12: Bit 0 of offset 0x24 is a read/write gating-allow bit that drives `gate_en_o` and resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational on bus_addr) |
| fault_evt | input | 1 | Engine reports a page fault (one cycle) |
| fault_addr_i | input | 32 | Faulting address, valid with fault_evt |
| fault_is_wr | input | 1 | Fault was a write access, valid with fault_evt |
| buserr_evt | input | 1 | Engine reports a table read bus error (one cycle) |
| engine_idle | input | 1 | Engine has no access in flight |
| replay_empty | input | 1 | Engine replay buffer is empty |
| tbl_base_o | output | 32 | Translation table base to the engine |
| paging_en_o | output | 1 | Translation enabled |
| stall_req_o | output | 1 | Engine must stop issuing accesses |
| fault_active_o | output | 1 | Engine is held on an unacknowledged fault |
| zap_all_o | output | 1 | One-cycle whole-cache invalidate |
| zap_line_o | output | 1 | One-cycle single-line invalidate |
| zap_line_addr_o | output | 32 | Address for the single-line invalidate |
| gate_en_o | output | 1 | Clock gating allowed |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check several rules. Stall active is never granted without a request held the cycle before. A stall request never rises during a fault or with paging off. Invalidate pulses occur only after the matching write. Events always latch into fault-active and the raw interrupt bits. A hard reset always empties table base and paging. The interrupt line never rises with an all-zero mask. Only the bench's scenarios can show the exact read-back values: the truncated table base, the captured fault address and direction, and the set-over-clear race on the raw bits. They also show that out-of-range command codes leave every register unchanged.

// File: rtl/mmu_ctl_pkg.sv
// Package: shared offsets, command codes and status bit positions for the
// MMU control register unit. Assumes a byte-addressed 32-bit register bus.
package mmu_ctl_pkg;
    localparam int REG_W   = 32;
    localparam int OFS_W   = 8;
    localparam int IRQ_N   = 2;
    localparam int PAGE_SH = 12;

    typedef enum logic [2:0] {
        CMD_PG_ON     = 3'd0,
        CMD_PG_OFF    = 3'd1,
        CMD_STALL_ON  = 3'd2,
        CMD_STALL_OFF = 3'd3,
        CMD_ZAP_ALL   = 3'd4,
        CMD_FAULT_ACK = 3'd5,
        CMD_HARD_RST  = 3'd6
    } mmu_cmd_e;

    localparam logic [OFS_W-1:0] OFS_TBASE  = 8'h00;
    localparam logic [OFS_W-1:0] OFS_STAT   = 8'h04;
    localparam logic [OFS_W-1:0] OFS_CMD    = 8'h08;
    localparam logic [OFS_W-1:0] OFS_FADDR  = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_ZLINE  = 8'h10;
    localparam logic [OFS_W-1:0] OFS_RAW    = 8'h14;
    localparam logic [OFS_W-1:0] OFS_CLR    = 8'h18;
    localparam logic [OFS_W-1:0] OFS_MASK   = 8'h1C;
    localparam logic [OFS_W-1:0] OFS_MSTAT  = 8'h20;
    localparam logic [OFS_W-1:0] OFS_GATE   = 8'h24;

    localparam int ST_PAGING = 0;
    localparam int ST_FAULT  = 1;
    localparam int ST_STALL  = 2;
    localparam int ST_IDLE   = 3;
    localparam int ST_REPLAY = 4;
    localparam int ST_FWRITE = 5;
    localparam int ST_NSTALL = 31;

    localparam int IRQ_FAULT  = 0;
    localparam int IRQ_BUSERR = 1;
endpackage

// File: rtl/mmu_cmd_ctrl.sv
// Module: command decoder and engine control state. It holds the paging,
// stall request, stall grant and fault state, and the captured fault
// information. It emits the whole-cache invalidate pulse. Assumes cmd_vld
// is a one-cycle strobe that carries an in-range code.
module mmu_cmd_ctrl
    import mmu_ctl_pkg::*;
#(
    parameter int AW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_vld,
    input  mmu_cmd_e      cmd_code,
    input  logic          fault_evt,
    input  logic [AW-1:0] fault_addr_i,
    input  logic          fault_is_wr,
    input  logic          engine_idle,
    output logic          hard_rst,
    output logic          paging_q,
    output logic          stall_req_q,
    output logic          stall_act_q,
    output logic          fault_act_q,
    output logic          fault_wr_q,
    output logic [AW-1:0] fault_addr_q,
    output logic          zap_all_q
);
    logic is_pg_on, is_pg_off, is_st_on, is_st_off, is_zap, is_ack;

    // Purpose: one-hot decode of the strobed command code.
    always_comb begin
        is_pg_on  = cmd_vld && (cmd_code == CMD_PG_ON);
        is_pg_off = cmd_vld && (cmd_code == CMD_PG_OFF);
        is_st_on  = cmd_vld && (cmd_code == CMD_STALL_ON);
        is_st_off = cmd_vld && (cmd_code == CMD_STALL_OFF);
        is_zap    = cmd_vld && (cmd_code == CMD_ZAP_ALL);
        is_ack    = cmd_vld && (cmd_code == CMD_FAULT_ACK);
        hard_rst  = cmd_vld && (cmd_code == CMD_HARD_RST);
    end

    // Purpose: paging flag follows enable/disable commands.
    always_ff @(posedge clk) begin
        if (!rst_n || hard_rst) paging_q <= 1'b0;
        else if (is_pg_on)      paging_q <= 1'b1;
        else if (is_pg_off)     paging_q <= 1'b0;
    end

    // Purpose: stall request, refused during a fault or with paging off.
    always_ff @(posedge clk) begin
        if (!rst_n || hard_rst)                      stall_req_q <= 1'b0;
        else if (is_st_on && paging_q && !fault_act_q) stall_req_q <= 1'b1;
        else if (is_st_off && paging_q)              stall_req_q <= 1'b0;
    end

    // Purpose: stall granted once the engine is idle under a held request.
    always_ff @(posedge clk) begin
        if (!rst_n || hard_rst) stall_act_q <= 1'b0;
        else                    stall_act_q <= stall_req_q && engine_idle;
    end

    // Purpose: fault-active set by the engine, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || hard_rst) fault_act_q <= 1'b0;
        else if (fault_evt)     fault_act_q <= 1'b1;
        else if (is_ack)        fault_act_q <= 1'b0;
    end

    // Purpose: capture the address and direction of the latest fault.
    always_ff @(posedge clk) begin
        if (!rst_n || hard_rst) begin
            fault_addr_q <= '0;
            fault_wr_q   <= 1'b0;
        end else if (fault_evt) begin
            fault_addr_q <= fault_addr_i;
            fault_wr_q   <= fault_is_wr;
        end
    end

    // Purpose: one-cycle whole-cache invalidate pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) zap_all_q <= 1'b0;
        else        zap_all_q <= is_zap;
    end
endmodule

// File: rtl/mmu_irq_unit.sv
// Module: raw interrupt latch, write-one-to-clear, mask and combined line.
// Assumes that an event and a clear of the same bit in one cycle leave
// the bit set.
module mmu_irq_unit #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic [N-1:0] evt,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    output logic [N-1:0] raw_q,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] masked,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_src
        // Purpose: per-cause latch where a new event wins over a clear.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr)         raw_q[i] <= 1'b0;
            else if (evt[i])                raw_q[i] <= 1'b1;
            else if (clr_we && clr_bits[i]) raw_q[i] <= 1'b0;
        end
    end

    // Purpose: software mask, all causes masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) mask_q <= '0;
        else if (mask_we)       mask_q <= mask_wdata;
    end

    // Purpose: masked view and combined interrupt line.
    always_comb begin
        masked = raw_q & mask_q;
        irq    = |masked;
    end
endmodule

// File: rtl/mmu_ctl_regs.sv
// Module: top of the MMU control register unit. It decodes bus writes into
// register updates and commands, and muxes read data. Assumes one access
// per strobed cycle and combinational read data.
module mmu_ctl_regs
    import mmu_ctl_pkg::*;
#(
    parameter int DW = REG_W,
    parameter int AW = OFS_W,
    parameter int PS = PAGE_SH,
    parameter int NI = IRQ_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          fault_evt,
    input  logic [DW-1:0] fault_addr_i,
    input  logic          fault_is_wr,
    input  logic          buserr_evt,
    input  logic          engine_idle,
    input  logic          replay_empty,
    output logic [DW-1:0] tbl_base_o,
    output logic          paging_en_o,
    output logic          stall_req_o,
    output logic          fault_active_o,
    output logic          zap_all_o,
    output logic          zap_line_o,
    output logic [DW-1:0] zap_line_addr_o,
    output logic          gate_en_o,
    output logic          irq_o
);
    localparam int TB_W = DW - PS;

    logic            wr_hit;
    logic            cmd_vld;
    logic            hard_rst;
    logic [TB_W-1:0] tbase_q;
    logic            gate_q;
    logic            zline_q;
    logic [DW-1:0]   zline_addr_q;
    logic            paging, stall_req, stall_act, fault_act, fault_wr;
    logic [DW-1:0]   fault_addr_q;
    logic [NI-1:0]   raw, mask, masked;
    logic [NI-1:0]   evts;
    logic [DW-1:0]   status;

    // Purpose: write strobe and command validity (codes 0..6 only).
    always_comb begin
        wr_hit  = bus_sel && bus_wr;
        cmd_vld = wr_hit && (bus_addr == OFS_CMD) &&
                  (bus_wdata[DW-1:3] == '0) && (bus_wdata[2:0] != 3'd7);
        evts    = '0;
        evts[IRQ_FAULT]  = fault_evt;
        evts[IRQ_BUSERR] = buserr_evt;
    end

    mmu_cmd_ctrl #(.AW(DW)) u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_vld      (cmd_vld),
        .cmd_code     (mmu_cmd_e'(bus_wdata[2:0])),
        .fault_evt    (fault_evt),
        .fault_addr_i (fault_addr_i),
        .fault_is_wr  (fault_is_wr),
        .engine_idle  (engine_idle),
        .hard_rst     (hard_rst),
        .paging_q     (paging),
        .stall_req_q  (stall_req),
        .stall_act_q  (stall_act),
        .fault_act_q  (fault_act),
        .fault_wr_q   (fault_wr),
        .fault_addr_q (fault_addr_q),
        .zap_all_q    (zap_all_o)
    );

    mmu_irq_unit #(.N(NI)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr   (hard_rst),
        .evt        (evts),
        .clr_we     (wr_hit && (bus_addr == OFS_CLR)),
        .clr_bits   (bus_wdata[NI-1:0]),
        .mask_we    (wr_hit && (bus_addr == OFS_MASK)),
        .mask_wdata (bus_wdata[NI-1:0]),
        .raw_q      (raw),
        .mask_q     (mask),
        .masked     (masked),
        .irq        (irq_o)
    );

    // Purpose: table base keeps only the page-aligned upper bits.
    always_ff @(posedge clk) begin
        if (!rst_n || hard_rst)                       tbase_q <= '0;
        else if (wr_hit && bus_addr == OFS_TBASE)     tbase_q <= bus_wdata[DW-1:PS];
    end

    // Purpose: clock-gating allow bit.
    always_ff @(posedge clk) begin
        if (!rst_n || hard_rst)                   gate_q <= 1'b0;
        else if (wr_hit && bus_addr == OFS_GATE)  gate_q <= bus_wdata[0];
    end

    // Purpose: single-line invalidate pulse with its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zline_q      <= 1'b0;
            zline_addr_q <= '0;
        end else begin
            zline_q <= wr_hit && (bus_addr == OFS_ZLINE);
            if (wr_hit && bus_addr == OFS_ZLINE) zline_addr_q <= bus_wdata;
        end
    end

    // Purpose: assemble the status word.
    always_comb begin
        status            = '0;
        status[ST_PAGING] = paging;
        status[ST_FAULT]  = fault_act;
        status[ST_STALL]  = stall_act;
        status[ST_IDLE]   = engine_idle;
        status[ST_REPLAY] = replay_empty;
        status[ST_FWRITE] = fault_wr;
        status[ST_NSTALL] = !stall_act;
    end

    // Purpose: read-data multiplexer; unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_TBASE: bus_rdata = {tbase_q, {PS{1'b0}}};
            OFS_STAT:  bus_rdata = status;
            OFS_FADDR: bus_rdata = fault_addr_q;
            OFS_RAW:   bus_rdata[NI-1:0] = raw;
            OFS_MASK:  bus_rdata[NI-1:0] = mask;
            OFS_MSTAT: bus_rdata[NI-1:0] = masked;
            OFS_GATE:  bus_rdata[0] = gate_q;
            default:   bus_rdata = '0;
        endcase
    end

    // Purpose: drive engine-facing outputs.
    always_comb begin
        tbl_base_o      = {tbase_q, {PS{1'b0}}};
        paging_en_o     = paging;
        stall_req_o     = stall_req;
        fault_active_o  = fault_act;
        zap_line_o      = zline_q;
        zap_line_addr_o = zline_addr_q;
        gate_en_o       = gate_q;
    end
endmodule

// File: rtl/mmu_ctl_regs_chk.sv
// Module: property checker for mmu_ctl_regs, attached with bind.
// Assumes the synchronous active-low reset of the checked block.
module mmu_ctl_regs_chk
    import mmu_ctl_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        fault_evt,
    input logic        buserr_evt,
    input logic        irq_o,
    input logic        zap_all_o,
    input logic        zap_line_o,
    input logic        paging,
    input logic        stall_req,
    input logic        stall_act,
    input logic        fault_act,
    input logic [1:0]  raw,
    input logic [1:0]  mask,
    input logic [31:0] tbl_base_o
);
    logic cmd_wr, hard_wr, zap_wr, zline_wr;
    assign cmd_wr   = bus_sel && bus_wr && (bus_addr == OFS_CMD);
    assign hard_wr  = cmd_wr && (bus_wdata == 32'd6);
    assign zap_wr   = cmd_wr && (bus_wdata == 32'd4);
    assign zline_wr = bus_sel && bus_wr && (bus_addr == OFS_ZLINE);

    a_r3_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        stall_act |-> $past(stall_req));
    a_r4_no_stall_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_req) |-> ($past(paging) && !$past(fault_act)));
    a_r5_fault_latch: assert property (@(posedge clk) disable iff (!rst_n)
        fault_evt |=> fault_act);
    a_r6_raw_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_evt && buserr_evt) |=> (raw == 2'b11));
    a_r7_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mask != 2'b00));
    a_r8_zap_all_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zap_all_o) |-> $past(zap_wr));
    a_r8_zap_line_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zap_line_o) |-> $past(zline_wr));
    a_r9_hard_reset: assert property (@(posedge clk) disable iff (!rst_n)
        hard_wr |=> (tbl_base_o == 32'd0 && !paging && !stall_req));
endmodule

bind mmu_ctl_regs mmu_ctl_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .fault_evt  (fault_evt),
    .buserr_evt (buserr_evt),
    .irq_o      (irq_o),
    .zap_all_o  (zap_all_o),
    .zap_line_o (zap_line_o),
    .paging     (paging),
    .stall_req  (stall_req),
    .stall_act  (stall_act),
    .fault_act  (fault_act),
    .raw        (raw),
    .mask       (mask),
    .tbl_base_o (tbl_base_o)
);

// File: tb/mmu_ctl_regs_bench.sv
// Bench: vector table for register and command basics, then directed
// scenarios for stall, faults, interrupts, invalidates and hard reset.
module mmu_ctl_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        fault_evt = 1'b0, fault_is_wr = 1'b0, buserr_evt = 1'b0;
    logic [31:0] fault_addr_i = '0;
    logic        engine_idle = 1'b0, replay_empty = 1'b0;
    logic [31:0] tbl_base_o, zap_line_addr_o;
    logic        paging_en_o, stall_req_o, fault_active_o;
    logic        zap_all_o, zap_line_o, gate_en_o, irq_o;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mmu_ctl_regs u_mmu_ctl_regs (.*);

    typedef struct packed {
        logic        rd;
        logic [7:0]  addr;
        logic [31:0] val;
        logic [3:0]  req;
    } vec_t;

    // Requirement tags by row: R1 table base, R2 paging, R10 bad codes,
    // R7 mask, R12 gating bit.
    localparam vec_t VEC [18] = '{
        '{1'b1, 8'h00, 32'h0000_0000, 4'd1},
        '{1'b0, 8'h00, 32'hCAFE_BABE, 4'd1},
        '{1'b1, 8'h00, 32'hCAFE_B000, 4'd1},
        '{1'b1, 8'h04, 32'h8000_0000, 4'd2},
        '{1'b0, 8'h08, 32'h0000_0000, 4'd2},
        '{1'b1, 8'h04, 32'h8000_0001, 4'd2},
        '{1'b0, 8'h08, 32'h0000_0007, 4'd10},
        '{1'b1, 8'h04, 32'h8000_0001, 4'd10},
        '{1'b0, 8'h08, 32'h0000_0101, 4'd10},
        '{1'b1, 8'h04, 32'h8000_0001, 4'd10},
        '{1'b0, 8'h08, 32'h0000_0001, 4'd2},
        '{1'b1, 8'h04, 32'h8000_0000, 4'd2},
        '{1'b1, 8'h1C, 32'h0000_0000, 4'd7},
        '{1'b0, 8'h1C, 32'h0000_0003, 4'd7},
        '{1'b1, 8'h1C, 32'h0000_0003, 4'd7},
        '{1'b0, 8'h1C, 32'h0000_0000, 4'd7},
        '{1'b0, 8'h24, 32'h0000_0001, 4'd12},
        '{1'b1, 8'h24, 32'h0000_0001, 4'd12}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a,
                          input logic [31:0] m, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v & m, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state of engine outputs (R7, R9 power-on values)
        check("R7 irq reset", {31'd0, irq_o}, 32'd0);
        check("R12 gate reset", {31'd0, gate_en_o}, 32'd0);

        for (int i = 0; i < 18; i++) begin
            if (VEC[i].rd) begin
                rd(VEC[i].addr, v);
                check($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].val);
            end else begin
                wr(VEC[i].addr, VEC[i].val);
            end
        end
        check("R1 tbl_base_o", tbl_base_o, 32'hCAFE_B000);
        check("R12 gate_en_o", {31'd0, gate_en_o}, 32'd1);

        // R11 idle and replay mirrors
        engine_idle = 1'b0; replay_empty = 1'b1;
        rd_chk("R11 replay bit", 8'h04, 32'h18, 32'h10);
        engine_idle = 1'b1; replay_empty = 1'b0;
        rd_chk("R11 idle bit", 8'h04, 32'h18, 32'h08);

        // R4: stall commands ignored with paging off
        wr(8'h08, 32'd2);
        check("R4 no req paging off", {31'd0, stall_req_o}, 32'd0);
        rd_chk("R4 no stall paging off", 8'h04, 32'h8000_0004, 32'h8000_0000);

        // R3: stall handshake waits for idle
        engine_idle = 1'b0;
        wr(8'h08, 32'd0);
        wr(8'h08, 32'd2);
        check("R3 req set", {31'd0, stall_req_o}, 32'd1);
        rd_chk("R3 not granted busy", 8'h04, 32'h8000_0004, 32'h8000_0000);
        engine_idle = 1'b1;
        rd_chk("R3 granted idle", 8'h04, 32'h8000_0004, 32'h0000_0004);

        // R5: fault capture
        @(negedge clk);
        fault_evt = 1'b1; fault_addr_i = 32'h1234_5678; fault_is_wr = 1'b1;
        @(negedge clk);
        fault_evt = 1'b0; fault_addr_i = 32'hFFFF_FFFF; fault_is_wr = 1'b0;
        check("R5 fault_active_o", {31'd0, fault_active_o}, 32'd1);
        rd_chk("R5 status fault+write", 8'h04, 32'h22, 32'h22);
        rd_chk("R5 fault addr", 8'h0C, 32'hFFFF_FFFF, 32'h1234_5678);

        // R3: stall off drops grant
        wr(8'h08, 32'd3);
        rd_chk("R3 stall released", 8'h04, 32'h8000_0004, 32'h8000_0000);
        // R4: stall on refused during fault
        wr(8'h08, 32'd2);
        check("R4 no req in fault", {31'd0, stall_req_o}, 32'd0);
        rd_chk("R4 no grant in fault", 8'h04, 32'h4, 32'h0);
        // R5: acknowledge
        wr(8'h08, 32'd5);
        rd_chk("R5 fault cleared", 8'h04, 32'h2, 32'h0);

        // R6/R7 interrupts
        @(negedge clk); buserr_evt = 1'b1;
        @(negedge clk); buserr_evt = 1'b0;
        rd_chk("R6 raw both", 8'h14, 32'hFFFF_FFFF, 32'h3);
        check("R7 irq masked off", {31'd0, irq_o}, 32'd0);
        wr(8'h1C, 32'h2);
        rd_chk("R7 masked status", 8'h20, 32'hFFFF_FFFF, 32'h2);
        check("R7 irq on", {31'd0, irq_o}, 32'd1);
        wr(8'h18, 32'h2);
        rd_chk("R6 clear bus err", 8'h14, 32'hFFFF_FFFF, 32'h1);
        check("R7 irq off after clear", {31'd0, irq_o}, 32'd0);
        // R6 set wins over clear in same cycle
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h1;
        fault_evt = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; fault_evt = 1'b0;
        rd_chk("R6 set wins", 8'h14, 32'hFFFF_FFFF, 32'h1);
        wr(8'h18, 32'h1);
        rd_chk("R6 cleared", 8'h14, 32'hFFFF_FFFF, 32'h0);
        wr(8'h08, 32'd5);

        // R8: invalidate pulses
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'd4;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R8 zap_all high", {31'd0, zap_all_o}, 32'd1);
        @(negedge clk);
        check("R8 zap_all one cycle", {31'd0, zap_all_o}, 32'd0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'hABCD_E000;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R8 zap_line high", {31'd0, zap_line_o}, 32'd1);
        check("R8 zap_line addr", zap_line_addr_o, 32'hABCD_E000);
        @(negedge clk);
        check("R8 zap_line one cycle", {31'd0, zap_line_o}, 32'd0);

        // R9: hard reset
        wr(8'h00, 32'h5555_5000);
        wr(8'h08, 32'd2);
        @(negedge clk); fault_evt = 1'b1; fault_addr_i = 32'h0000_4444;
        @(negedge clk); fault_evt = 1'b0;
        wr(8'h1C, 32'h3);
        wr(8'h24, 32'h1);
        wr(8'h08, 32'd6);
        rd_chk("R9 tbase zero", 8'h00, 32'hFFFF_FFFF, 32'h0);
        rd_chk("R9 status", 8'h04, 32'h8000_0027, 32'h8000_0000);
        rd_chk("R9 fault addr", 8'h0C, 32'hFFFF_FFFF, 32'h0);
        rd_chk("R9 raw", 8'h14, 32'hFFFF_FFFF, 32'h0);
        rd_chk("R9 mask", 8'h1C, 32'hFFFF_FFFF, 32'h0);
        check("R9 gate", {31'd0, gate_en_o}, 32'd0);
        check("R9 irq", {31'd0, irq_o}, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule